// File: doc/BRIEF.md
# CSMA/CA Random Backoff Engine

This block decides when a low-rate wireless MAC may start a transmission on a shared channel. A request starts a sequence of attempts. For each attempt the engine puts the radio back to idle and draws a random backoff from a 32-bit LFSR. It then waits that many backoff units and asks the radio for a clear-channel assessment (CCA). A clear result launches the transmit sequence, which is transmit-only or transmit-then-receive depending on whether an acknowledgement was asked for. A busy result widens the backoff window and retries until the retry budget runs out. At that point a medium-busy failure is reported.

Three 8-bit settings can be written while the engine is idle: the lowest backoff exponent, the highest backoff exponent, and the number of busy retries allowed. Time is counted in timer ticks of `TICK_CYCLES` clocks. One backoff unit lasts `UNIT_TICKS` ticks. With the defaults (2000 clocks at 125 MHz, 20 ticks) a tick is 16 µs and a unit is 320 µs. When acknowledgement is requested, the engine also watches a window of `ACK_TICKS` ticks (54 ticks, 864 µs) after the last transmitted bit. It aborts the sequence if the radio has not finished by the end of that window.

Top module: `csma_backoff_engine`

## Requirements
- R1: After reset the lowest exponent is 3, the highest exponent is 5 and the retry budget is 4.
- R2: A write with `cfg_we` high stores `cfg_wdata` only while `busy` is low. Address 0 sets the lowest exponent, 1 the highest exponent and 2 the retry budget. Address 3 and any write while busy change nothing.
- R3: An accepted request loads the exponent BE with the lowest exponent and clears the retry count. `radio_idle` pulses in the cycle after the request. `cca_req` pulses exactly draw*`UNIT_TICKS`*`TICK_CYCLES`+1 cycles after `radio_idle`.
- R4: The random word comes from a Galois LFSR that shifts right and XORs 32'h80200003 into the word when the bit shifted out is 1. It starts at `LFSR_SEED` and advances once per draw. The draw is the top min(BE,32) bits of the word before the advance. A draw of 0 becomes 1.
- R5: A CCA result with `cca_busy`=1 and retry count below the budget increments the count, raises BE by one unless it already equals or exceeds the highest exponent, and starts a new attempt with `radio_idle`.
- R6: A busy result once the count equals the budget pulses `fail_busy` for one cycle and returns to idle, so budget+1 CCAs are made.
- R7: A clear result (`cca_done`=1, `cca_busy`=0) pulses `tx_start` one cycle later. `tx_with_rx` is high with it exactly when the request carried `tx_ack_req`. `seq_done` then gives a one-cycle `done` on the next cycle.
- R8: With acknowledgement requested, `tx_frame_end` opens a window of `ACK_TICKS`*`TICK_CYCLES` cycles. If `seq_done` has not arrived by its end, `seq_abort` and `fail_noack` pulse together on the next cycle. An earlier `seq_done` gives `done` instead.
- R9: `trig_armed` is high on every cycle strictly between an attempt's `radio_idle` and its `cca_req`.
- R10: A request with `csma_en` low skips backoff and CCA. `tx_start` pulses the cycle after `radio_idle`, and the LFSR does not advance.
- R11: `busy` is high from the cycle after an accepted request through the result pulse. A request arriving while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Setting write strobe |
| cfg_addr | input | 2 | Setting select (0 low BE, 1 high BE, 2 retry budget) |
| cfg_wdata | input | CFG_W | Setting value |
| tx_req | input | 1 | Start a transmission (one-cycle strobe) |
| tx_ack_req | input | 1 | Frame asks for acknowledgement, sampled with tx_req |
| csma_en | input | 1 | Use backoff and CCA, sampled with tx_req |
| radio_idle | output | 1 | Put the radio into idle before an attempt |
| trig_armed | output | 1 | Timer-triggered start is armed |
| cca_req | output | 1 | Request a clear-channel assessment |
| cca_done | input | 1 | CCA result valid |
| cca_busy | input | 1 | CCA found the channel busy |
| tx_start | output | 1 | Launch the transmit sequence |
| tx_with_rx | output | 1 | Launched sequence is transmit-then-receive |
| tx_frame_end | input | 1 | Last bit of the frame has been sent |
| seq_done | input | 1 | Radio sequence finished |
| seq_abort | output | 1 | Abort the radio sequence |
| done | output | 1 | Transmission complete |
| fail_busy | output | 1 | Gave up: channel stayed busy |
| fail_noack | output | 1 | Gave up: acknowledgement window expired |
| busy | output | 1 | Engine is handling a request |

## Verification
The bench builds the engine with `UNIT_TICKS`=4 and `TICK_CYCLES`=2, so each backoff unit lasts eight clocks. A full default retry chain (exponents 3, 4, 5, 5, 5) then runs in a few hundred cycles. The tick prescaler is still exercised, so every backoff gap can be compared to the cycle against an LFSR model of its own. `ACK_TICKS` keeps its value of 54, which places the acknowledgement timeout at 109 cycles. `LFSR_SEED`=1 makes the very first draw zero, so the zero-to-one substitution is reached at once.

// File: rtl/csma_pkg.sv
package csma_pkg;

   typedef enum logic [3:0] {
      S_IDLE,
      S_PREP,
      S_WAIT,
      S_CCA_REQ,
      S_CCA_WAIT,
      S_START,
      S_TX,
      S_ACKW,
      S_DONE,
      S_FAILB,
      S_FAILN
   } csma_state_e;

   typedef enum logic [1:0] {
      CFG_MIN_BE = 2'd0,
      CFG_MAX_BE = 2'd1,
      CFG_MAX_NB = 2'd2,
      CFG_RSVD   = 2'd3
   } cfg_addr_e;

endpackage

// File: rtl/csma_lfsr.sv
module csma_lfsr #(
   parameter int               W    = 32,
   parameter logic [W-1:0]     MASK = 32'h8020_0003,
   parameter logic [W-1:0]     SEED = 32'h0000_0001
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         step,
   output logic [W-1:0] word
);

   generate
      if (SEED == '0) begin : g_bad_seed
         $error("csma_lfsr: seed must be nonzero");
      end
      if (MASK[W-1] != 1'b1) begin : g_bad_mask
         $error("csma_lfsr: mask must have its top bit set");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         word <= SEED;
      end else if (step) begin
         word <= {1'b0, word[W-1:1]} ^ (word[0] ? MASK : '0);
      end
   end

   AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      word != '0);  // R4

endmodule

// File: rtl/csma_timer.sv
module csma_timer #(
   parameter int CNT_W       = 32,
   parameter int UT_W        = 5,
   parameter int TICK_CYCLES = 2000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             stop,
   input  logic [CNT_W-1:0] load_units,
   input  logic [UT_W-1:0]  load_ut,
   output logic             expire,
   output logic             running
);

   logic [CNT_W-1:0] units_q;
   logic [UT_W-1:0]  ut_q;
   logic [UT_W-1:0]  tc_q;
   logic             tick_end;
   logic             unit_end;

   generate
      if (TICK_CYCLES < 1) begin : g_bad_tick
         $error("csma_timer: TICK_CYCLES must be at least 1");
      end
      if (TICK_CYCLES > 1) begin : g_prescale
         localparam int PC_W = $clog2(TICK_CYCLES);
         logic [PC_W-1:0] pc_q;
         always_ff @(posedge clk) begin
            if (!rst_n || load) begin
               pc_q <= '0;
            end else if (running) begin
               pc_q <= (pc_q == PC_W'(TICK_CYCLES - 1)) ? '0 : pc_q + 1'b1;
            end
         end
         assign tick_end = (pc_q == PC_W'(TICK_CYCLES - 1));
      end else begin : g_direct
         assign tick_end = 1'b1;
      end
   endgenerate

   assign unit_end = (tc_q == ut_q - 1'b1);
   assign expire   = running && tick_end && unit_end && (units_q == CNT_W'(1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         running <= 1'b0;
         units_q <= '0;
         ut_q    <= '0;
         tc_q    <= '0;
      end else if (load) begin
         running <= 1'b1;
         units_q <= load_units;
         ut_q    <= load_ut;
         tc_q    <= '0;
      end else if (stop || expire) begin
         running <= 1'b0;
      end else if (running && tick_end) begin
         if (unit_end) begin
            tc_q    <= '0;
            units_q <= units_q - 1'b1;
         end else begin
            tc_q <= tc_q + 1'b1;
         end
      end
   end

   AST_LOAD_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      load |-> (load_units != '0) && (load_ut != '0));  // R4

endmodule

// File: rtl/csma_cfg.sv
module csma_cfg
   import csma_pkg::*;
#(
   parameter int CFG_W      = 8,
   parameter int DEF_MIN_BE = 3,
   parameter int DEF_MAX_BE = 5,
   parameter int DEF_MAX_NB = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             lock,
   input  logic             wr_en,
   input  logic [1:0]       wr_addr,
   input  logic [CFG_W-1:0] wr_data,
   output logic [CFG_W-1:0] min_be,
   output logic [CFG_W-1:0] max_be,
   output logic [CFG_W-1:0] max_nb
);

   logic accept;
   assign accept = wr_en && !lock;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         min_be <= CFG_W'(DEF_MIN_BE);
         max_be <= CFG_W'(DEF_MAX_BE);
         max_nb <= CFG_W'(DEF_MAX_NB);
      end else if (accept) begin
         case (cfg_addr_e'(wr_addr))
            CFG_MIN_BE: min_be <= wr_data;
            CFG_MAX_BE: max_be <= wr_data;
            CFG_MAX_NB: max_nb <= wr_data;
            default:    ;
         endcase
      end
   end

   AST_CFG_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      lock |=> $stable(min_be) && $stable(max_be) && $stable(max_nb));  // R2

endmodule

// File: rtl/csma_backoff_engine.sv
module csma_backoff_engine
   import csma_pkg::*;
#(
   parameter int                RAND_W      = 32,
   parameter int                CFG_W       = 8,
   parameter int                UNIT_TICKS  = 20,
   parameter int                TICK_CYCLES = 2000,
   parameter int                ACK_TICKS   = 54,
   parameter logic [RAND_W-1:0] LFSR_MASK   = 32'h8020_0003,
   parameter logic [RAND_W-1:0] LFSR_SEED   = 32'h0000_0001,
   parameter int                DEF_MIN_BE  = 3,
   parameter int                DEF_MAX_BE  = 5,
   parameter int                DEF_MAX_NB  = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic [1:0]       cfg_addr,
   input  logic [CFG_W-1:0] cfg_wdata,
   input  logic             tx_req,
   input  logic             tx_ack_req,
   input  logic             csma_en,
   output logic             radio_idle,
   output logic             trig_armed,
   output logic             cca_req,
   input  logic             cca_done,
   input  logic             cca_busy,
   output logic             tx_start,
   output logic             tx_with_rx,
   input  logic             tx_frame_end,
   input  logic             seq_done,
   output logic             seq_abort,
   output logic             done,
   output logic             fail_busy,
   output logic             fail_noack,
   output logic             busy
);

   localparam int SH_W  = $clog2(RAND_W + 1);
   localparam int UT_W  = $clog2(UNIT_TICKS + 1);
   localparam int CNT_W = RAND_W;

   generate
      if (UNIT_TICKS < 1 || ACK_TICKS < 1) begin : g_bad_time
         $error("csma_backoff_engine: unit and ack windows must be nonzero");
      end
      if ($clog2(ACK_TICKS + 1) > CNT_W) begin : g_bad_ack
         $error("csma_backoff_engine: ACK_TICKS does not fit the unit counter");
      end
      if (CFG_W < SH_W) begin : g_bad_cfg
         $error("csma_backoff_engine: CFG_W too narrow for the exponent range");
      end
   endgenerate

   csma_state_e      state_q, state_d;
   logic [CFG_W-1:0] min_be, max_be, max_nb;
   logic [CFG_W-1:0] be_q, nb_q;
   logic             ack_q, csma_q;

   logic [RAND_W-1:0] rnd_word;
   logic [SH_W-1:0]   be_eff;
   logic [RAND_W-1:0] rnd_top;
   logic [CNT_W-1:0]  draw_units;

   logic             tmr_load, tmr_stop, tmr_expire, tmr_running;
   logic [CNT_W-1:0] tmr_units;
   logic [UT_W-1:0]  tmr_ut;
   logic             draw_now;

   // ---------------- settings ----------------
   csma_cfg #(
      .CFG_W      (CFG_W),
      .DEF_MIN_BE (DEF_MIN_BE),
      .DEF_MAX_BE (DEF_MAX_BE),
      .DEF_MAX_NB (DEF_MAX_NB)
   ) i_cfg (
      .clk     (clk),
      .rst_n   (rst_n),
      .lock    (busy),
      .wr_en   (cfg_we),
      .wr_addr (cfg_addr),
      .wr_data (cfg_wdata),
      .min_be  (min_be),
      .max_be  (max_be),
      .max_nb  (max_nb)
   );

   // ---------------- random draw ----------------
   assign draw_now = (state_q == S_PREP) && csma_q;

   csma_lfsr #(
      .W    (RAND_W),
      .MASK (LFSR_MASK),
      .SEED (LFSR_SEED)
   ) i_lfsr (
      .clk   (clk),
      .rst_n (rst_n),
      .step  (draw_now),
      .word  (rnd_word)
   );

   assign be_eff     = (be_q > CFG_W'(RAND_W)) ? SH_W'(RAND_W) : SH_W'(be_q);
   assign rnd_top    = (be_eff == '0) ? '0 : (rnd_word >> (SH_W'(RAND_W) - be_eff));
   assign draw_units = (rnd_top == '0) ? CNT_W'(1) : rnd_top;

   // ---------------- shared timer ----------------
   assign tmr_load  = draw_now ||
                      ((state_q == S_TX) && ack_q && tx_frame_end && !seq_done);
   assign tmr_stop  = (state_q == S_ACKW) && seq_done;
   assign tmr_units = draw_now ? draw_units : CNT_W'(ACK_TICKS);
   assign tmr_ut    = draw_now ? UT_W'(UNIT_TICKS) : UT_W'(1);

   csma_timer #(
      .CNT_W       (CNT_W),
      .UT_W        (UT_W),
      .TICK_CYCLES (TICK_CYCLES)
   ) i_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (tmr_load),
      .stop       (tmr_stop),
      .load_units (tmr_units),
      .load_ut    (tmr_ut),
      .expire     (tmr_expire),
      .running    (tmr_running)
   );

   // ---------------- sequencing ----------------
   always_comb begin
      state_d = state_q;
      unique case (state_q)
         S_IDLE:     if (tx_req) state_d = S_PREP;
         S_PREP:     state_d = csma_q ? S_WAIT : S_START;
         S_WAIT:     if (tmr_expire) state_d = S_CCA_REQ;
         S_CCA_REQ:  state_d = S_CCA_WAIT;
         S_CCA_WAIT: begin
            if (cca_done) begin
               if (!cca_busy)           state_d = S_START;
               else if (nb_q < max_nb)  state_d = S_PREP;
               else                     state_d = S_FAILB;
            end
         end
         S_START:    state_d = S_TX;
         S_TX: begin
            if (seq_done)                        state_d = S_DONE;
            else if (ack_q && tx_frame_end)      state_d = S_ACKW;
         end
         S_ACKW: begin
            if (seq_done)        state_d = S_DONE;
            else if (tmr_expire) state_d = S_FAILN;
         end
         default:    state_d = S_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= S_IDLE;
         be_q    <= '0;
         nb_q    <= '0;
         ack_q   <= 1'b0;
         csma_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         if (state_q == S_IDLE && tx_req) begin
            be_q   <= min_be;
            nb_q   <= '0;
            ack_q  <= tx_ack_req;
            csma_q <= csma_en;
         end else if (state_q == S_CCA_WAIT && cca_done && cca_busy && nb_q < max_nb) begin
            nb_q <= nb_q + 1'b1;
            if (be_q < max_be) be_q <= be_q + 1'b1;
         end
      end
   end

   assign radio_idle = (state_q == S_PREP);
   assign trig_armed = (state_q == S_WAIT);
   assign cca_req    = (state_q == S_CCA_REQ);
   assign tx_start   = (state_q == S_START);
   assign tx_with_rx = (state_q == S_START) && ack_q;
   assign seq_abort  = (state_q == S_FAILN);
   assign fail_noack = (state_q == S_FAILN);
   assign fail_busy  = (state_q == S_FAILB);
   assign done       = (state_q == S_DONE);
   assign busy       = (state_q != S_IDLE);

   // ---------------- checks ----------------
   AST_NB_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != S_IDLE) |-> (nb_q <= max_nb));  // R6
   AST_BE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != S_IDLE) |-> (be_q <= max_be || be_q == min_be));  // R5
   AST_FAIL_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      fail_busy |-> $past(cca_done && cca_busy));  // R6
   AST_START_AFTER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_start && csma_q) |-> $past(cca_done && !cca_busy));  // R7
   AST_DIRECT_START: assert property (@(posedge clk) disable iff (!rst_n)
      (radio_idle && !csma_q) |=> tx_start);  // R10
   AST_NOACK_NO_SEQ_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      fail_noack |-> !$past(seq_done));  // R8
   AST_ARMED_TIMER: assert property (@(posedge clk) disable iff (!rst_n)
      trig_armed |-> tmr_running);  // R9

endmodule

// File: tb/test_csma_backoff_engine.sv
module test_csma_backoff_engine;

   localparam int UNIT_TICKS  = 4;
   localparam int TICK_CYCLES = 2;
   localparam int ACK_TICKS   = 54;
   localparam int UNIT_CYC    = UNIT_TICKS * TICK_CYCLES;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_we = 1'b0;
   logic [1:0] cfg_addr = '0;
   logic [7:0] cfg_wdata = '0;
   logic tx_req = 1'b0, tx_ack_req = 1'b0, csma_en = 1'b1;
   logic cca_done = 1'b0, cca_busy = 1'b0;
   logic tx_frame_end = 1'b0, seq_done = 1'b0;
   logic radio_idle, trig_armed, cca_req, tx_start, tx_with_rx;
   logic seq_abort, done, fail_busy, fail_noack, busy;

   always #4 clk = ~clk;

   csma_backoff_engine #(
      .UNIT_TICKS  (UNIT_TICKS),
      .TICK_CYCLES (TICK_CYCLES),
      .ACK_TICKS   (ACK_TICKS),
      .LFSR_SEED   (32'h1)
   ) i_csma_backoff_engine (
      .clk (clk), .rst_n (rst_n),
      .cfg_we (cfg_we), .cfg_addr (cfg_addr), .cfg_wdata (cfg_wdata),
      .tx_req (tx_req), .tx_ack_req (tx_ack_req), .csma_en (csma_en),
      .radio_idle (radio_idle), .trig_armed (trig_armed), .cca_req (cca_req),
      .cca_done (cca_done), .cca_busy (cca_busy),
      .tx_start (tx_start), .tx_with_rx (tx_with_rx),
      .tx_frame_end (tx_frame_end), .seq_done (seq_done),
      .seq_abort (seq_abort), .done (done), .fail_busy (fail_busy),
      .fail_noack (fail_noack), .busy (busy)
   );

   int checks = 0, fails = 0;
   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   // ---------------- bench model ----------------
   logic [31:0] m_word = 32'h1;
   int m_min = 3, m_max = 5, m_nb = 4;
   int e_be, e_nb;
   bit csma_mode = 1'b1;
   int busy_left = 0;

   function automatic longint draw_of(input logic [31:0] w, input int be);
      int b;
      longint r;
      b = (be > 32) ? 32 : be;
      r = (b == 0) ? 0 : longint'(w >> (32 - b));
      if (r == 0) r = 1;
      return r;
   endfunction

   // ---------------- monitor / CCA responder ----------------
   int n_idle, n_cca, n_tx, n_done, n_failb, n_failn, n_abort;
   int t_idle, t_tx, t_failn, t_abort;
   bit last_rx;
   bit in_wait, arm_ok, cca_pending;
   longint e_units;

   task automatic clear_counts();
      n_idle = 0; n_cca = 0; n_tx = 0; n_done = 0;
      n_failb = 0; n_failn = 0; n_abort = 0;
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         if (cca_pending) begin
            cca_done = 1'b1;
            cca_busy = (busy_left > 0);
            if (busy_left > 0) begin
               busy_left--;
               if (e_nb < m_nb) begin
                  e_nb++;
                  if (e_be < m_max) e_be++;
               end
            end
            cca_pending = 1'b0;
         end else begin
            cca_done = 1'b0;
            cca_busy = 1'b0;
         end
         if (radio_idle) begin
            n_idle++;
            t_idle = cyc;
            if (csma_mode) begin
               e_units = draw_of(m_word, e_be);
               m_word  = (m_word >> 1) ^ (m_word[0] ? 32'h8020_0003 : 32'h0);
               in_wait = 1'b1;
               arm_ok  = 1'b1;
            end
         end else if (in_wait && !cca_req && !trig_armed) begin
            arm_ok = 1'b0;
         end
         if (cca_req) begin
            n_cca++;
            in_wait = 1'b0;
            // R3 R4 R5: gap from radio_idle to cca_req
            check(cyc - t_idle == e_units * UNIT_CYC + 1, "R3/R4 backoff gap",
                  cyc - t_idle, e_units * UNIT_CYC + 1);
            check(arm_ok, "R9 trig_armed through wait", arm_ok, 1);
            cca_pending = 1'b1;
         end
         if (tx_start) begin n_tx++; t_tx = cyc; last_rx = tx_with_rx; end
         if (done) n_done++;
         if (fail_busy) n_failb++;
         if (fail_noack) begin n_failn++; t_failn = cyc; end
         if (seq_abort) begin n_abort++; t_abort = cyc; end
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic cfg_write(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic request(input bit ack, input bit use_csma, input int nbusy);
      clear_counts();
      @(negedge clk);
      csma_mode = use_csma;
      busy_left = nbusy;
      e_be = m_min; e_nb = 0;
      tx_req = 1'b1; tx_ack_req = ack; csma_en = use_csma;
      @(negedge clk);
      tx_req = 1'b0; tx_ack_req = 1'b0; csma_en = 1'b1;
   endtask

   task automatic wait_tx_or_fail();
      for (int i = 0; i < 20000; i++) begin
         if (n_tx > 0 || n_failb > 0) break;
         @(negedge clk);
      end
   endtask

   task automatic finish_seq();
      @(negedge clk);
      seq_done = 1'b1;
      @(negedge clk);
      seq_done = 1'b0;
      @(negedge clk);
   endtask

   // ---------------- scenarios ----------------
   task automatic t_reset();
      check(busy == 1'b0, "R11 busy low after reset", busy, 0);
      check({radio_idle, cca_req, tx_start, done, fail_busy, fail_noack, seq_abort} == '0,
            "R11 outputs quiet after reset",
            {radio_idle, cca_req, tx_start, done, fail_busy, fail_noack, seq_abort}, 0);
   endtask

   task automatic t_default_success();
      // R1 R3 R5 R7: defaults, two busy retries then clear
      request(1'b0, 1'b1, 2);
      check(busy == 1'b1, "R11 busy after request", busy, 1);
      wait_tx_or_fail();
      check(n_cca == 3, "R5 CCA count after two busy", n_cca, 3);
      check(n_idle == 3, "R5 radio_idle per attempt", n_idle, 3);
      check(n_tx == 1 && last_rx == 1'b0, "R7 transmit-only start", last_rx, 0);
      finish_seq();
      check(n_done == 1, "R7 done after seq_done", n_done, 1);
      check(busy == 1'b0, "R11 idle after done", busy, 0);
   endtask

   task automatic t_default_fail();
      // R1 R6: default budget 4 gives 5 CCAs, BE 3,4,5,5,5
      request(1'b0, 1'b1, 100);
      wait_tx_or_fail();
      @(negedge clk);
      check(n_cca == 5, "R1/R6 CCAs before giving up", n_cca, 5);
      check(n_failb == 1 && n_tx == 0, "R6 fail_busy without transmit", n_failb, 1);
      busy_left = 0;
   endtask

   task automatic t_cfg_write();
      // R2: new settings low 1, high 2, budget 1; address 3 ignored
      cfg_write(2'd0, 8'd1); m_min = 1;
      cfg_write(2'd1, 8'd2); m_max = 2;
      cfg_write(2'd2, 8'd1); m_nb = 1;
      cfg_write(2'd3, 8'd9);
      request(1'b0, 1'b1, 10);
      wait_tx_or_fail();
      @(negedge clk);
      check(n_cca == 2, "R2 budget 1 gives two CCAs", n_cca, 2);
      check(n_failb == 1, "R2 fail after new budget", n_failb, 1);
      busy_left = 0;
   endtask

   task automatic t_busy_ignore();
      // R2 R11: writes and requests during a transaction are dropped
      request(1'b0, 1'b1, 0);
      cfg_write(2'd2, 8'd7);
      cfg_write(2'd0, 8'd6);
      @(negedge clk);
      tx_req = 1'b1;
      @(negedge clk);
      tx_req = 1'b0;
      wait_tx_or_fail();
      finish_seq();
      repeat (4) @(negedge clk);
      check(n_idle == 1 && n_tx == 1, "R11 second request ignored", n_idle, 1);
      check(busy == 1'b0, "R11 idle after ignored request", busy, 0);
      request(1'b0, 1'b1, 10);
      wait_tx_or_fail();
      @(negedge clk);
      check(n_cca == 2, "R2 budget unchanged by busy write", n_cca, 2);
      busy_left = 0;
   endtask

   task automatic t_ack_timeout();
      int c0;
      // R8: no seq_done inside the window
      request(1'b1, 1'b1, 0);
      wait_tx_or_fail();
      check(last_rx == 1'b1, "R7 transmit-then-receive selected", last_rx, 1);
      @(negedge clk);
      tx_frame_end = 1'b1; c0 = cyc;
      @(negedge clk);
      tx_frame_end = 1'b0;
      for (int i = 0; i < 500; i++) begin
         if (n_failn > 0) break;
         @(negedge clk);
      end
      check(t_failn - c0 == ACK_TICKS * TICK_CYCLES + 1, "R8 ack window length",
            t_failn - c0, ACK_TICKS * TICK_CYCLES + 1);
      check(n_abort == 1 && t_abort == t_failn, "R8 abort with fail_noack", n_abort, 1);
      check(n_done == 0, "R8 no done on timeout", n_done, 0);
   endtask

   task automatic t_ack_ok();
      // R8: seq_done inside the window gives done
      request(1'b1, 1'b1, 1);
      wait_tx_or_fail();
      @(negedge clk);
      tx_frame_end = 1'b1;
      @(negedge clk);
      tx_frame_end = 1'b0;
      repeat (20) @(negedge clk);
      finish_seq();
      repeat (ACK_TICKS * TICK_CYCLES) @(negedge clk);
      check(n_done == 1 && n_failn == 0, "R8 ack in time gives done", n_done, 1);
   endtask

   task automatic t_no_csma();
      // R10: direct start, no CCA, LFSR untouched (next gap check relies on it)
      request(1'b0, 1'b0, 0);
      wait_tx_or_fail();
      check(t_tx - t_idle == 1, "R10 start right after idle", t_tx - t_idle, 1);
      check(n_cca == 0, "R10 no CCA", n_cca, 0);
      finish_seq();
      check(n_done == 1, "R10 done", n_done, 1);
      request(1'b0, 1'b1, 0);
      wait_tx_or_fail();
      check(n_cca == 1, "R10 LFSR not advanced, next draw checked", n_cca, 1);
      finish_seq();
   endtask

   task automatic t_wide_be();
      // R4 R5: larger exponents, budget 2
      cfg_write(2'd0, 8'd6); m_min = 6;
      cfg_write(2'd1, 8'd7); m_max = 7;
      cfg_write(2'd2, 8'd2); m_nb = 2;
      request(1'b0, 1'b1, 5);
      wait_tx_or_fail();
      @(negedge clk);
      check(n_cca == 3 && n_failb == 1, "R5 wide exponent retry chain", n_cca, 3);
      busy_left = 0;
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      check(1'b0, "watchdog", cyc, 0);
      summary();
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset();
      t_default_success();
      t_default_fail();
      t_ack_timeout();
      t_ack_ok();
      t_no_csma();
      t_cfg_write();
      t_busy_ignore();
      t_wide_be();
      repeat (5) @(negedge clk);
      summary();
   end

endmodule